// File: doc/BRIEF.md
# Sign-Error Shift-Based LMS Weight Updater

This block adapts the four coefficients of a four-tap adaptive FIR filter using a least-mean-squares rule that needs no multiplier. When the update strobe is high, the block forms the error as desired sample minus filter output. It splits that error into a sign and a magnitude. The magnitude is reduced to the position of its highest set bit, so it becomes a power of two. That position selects how far each captured input sample is shifted right. The shifted sample is then added to its weight when the error is positive, or subtracted from it when the error is negative. The addition saturates at the two's-complement limits of the weight word.

The step size 1/N (N = 4 taps) is applied as an extra right shift of log2(N). A further `MU_EXTRA` shift scales the step by 2^(−i). The error is treated as a fraction of 2^DW. The largest possible error shifts a sample right by the step shift alone. Each halving of the error adds one more position of shift.

The work is done by a three-state controller. Because of it, every update lands a fixed two cycles after its strobe is taken, which is the adaptation delay. The inner product that produces the filter output is computed elsewhere and enters as `y_i`.

Top module: `lms_sign_updater`

## Requirements
- R1: A synchronous active-high `rst` clears all four weights to zero at the next rising edge and returns the controller to `ST_WAIT`.
- R2: The error is `d_i − y_i`, computed in DW+1 bits. A positive error adds the shifted sample to the weight; a negative error subtracts it.
- R3: If p is the bit index of the highest set bit of |error|, each sample is shifted right arithmetically (sign-filling) by (DW−1−p)+log2(4)+MU_EXTRA before it is added or subtracted.
- R4: An error of exactly zero leaves all four weights unchanged.
- R5: The weights keep their values on any cycle in which no update is being committed. This includes every cycle where `upd_i` stays low while the other inputs change.
- R6: A strobe is accepted only in `ST_WAIT`. The new weights appear on the third rising edge, counting the accepting edge as the first. Strobes during the two cycles that follow acceptance are ignored.
- R7: A sum above 2^(WW−1)−1 is clamped to 2^(WW−1)−1.
- R8: A sum below −2^(WW−1) is clamped to −2^(WW−1).
- R9: Controller states and transitions:
  - `ST_WAIT` goes to `ST_GRADE` on a strobe and stays in `ST_WAIT` otherwise.
  - `ST_GRADE`, which derives the shift, always goes to `ST_COMMIT`.
  - `ST_COMMIT`, which writes the weights, always goes to `ST_WAIT`.
- R10: Weight k is updated only from sample input k. All four samples are captured on the accepting edge, so later changes on the sample inputs do not affect a pending update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update strobe |
| y_i | input | DW | Filter output, signed |
| d_i | input | DW | Desired sample, signed |
| x0_i | input | DW | Delayed input sample for tap 0, signed |
| x1_i | input | DW | Delayed input sample for tap 1, signed |
| x2_i | input | DW | Delayed input sample for tap 2, signed |
| x3_i | input | DW | Delayed input sample for tap 3, signed |
| w0_o | output | WW | Weight 0, signed |
| w1_o | output | WW | Weight 1, signed |
| w2_o | output | WW | Weight 2, signed |
| w3_o | output | WW | Weight 3, signed |

## Verification
Weights cleared by reset are visible after the reset edge. A weight update is due two edges after the edge that takes the strobe, and the weights must not move in between. The reference model in the bench stores each accepted update with a countdown of two edges and applies it when the countdown reaches zero. A strobe that arrives while the countdown runs is not accepted by the model, which mirrors R6. All four weights are compared against the model at every falling edge, which is half a period after each update edge. An early, late or missed update therefore shows up in the cycle where it happens.

// File: rtl/lms_upd_pkg.sv
package lms_upd_pkg;

    // Controller states of the weight updater
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_GRADE  = 2'd1,
        ST_COMMIT = 2'd2
    } upd_state_e;

endpackage

// File: rtl/lms_lead_one.sv
// Finds the index of the highest set bit of an unsigned word.
module lms_lead_one #(
    parameter  int MW = 17,
    localparam int PW = $clog2(MW)
) (
    input  logic [MW-1:0] mag,
    output logic [PW-1:0] pos,
    output logic          none
);

    always_comb begin
        pos  = '0;
        none = 1'b1;
        for (int i = 0; i < MW; i++) begin
            if (mag[i]) begin
                pos  = PW'(i);
                none = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lms_tap_cell.sv
// One tap: barrel shift of the captured sample, add or subtract, saturate.
module lms_tap_cell #(
    parameter int DW  = 16,
    parameter int WW  = 16,
    parameter int SHW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 sub,
    input  logic [SHW-1:0]       sh,
    input  logic signed [DW-1:0] x,
    output logic signed [WW-1:0] w
);

    localparam logic signed [WW:0] W_MAX = (WW+1)'((64'sd1 <<< (WW-1)) - 64'sd1);
    localparam logic signed [WW:0] W_MIN = (WW+1)'(-(64'sd1 <<< (WW-1)));

    logic signed [WW:0] x_ext;
    logic signed [WW:0] inc;
    logic signed [WW:0] w_ext;
    logic signed [WW:0] sum;
    logic signed [WW-1:0] w_next;

    assign x_ext = (WW+1)'(x);
    assign inc   = x_ext >>> sh;
    assign w_ext = (WW+1)'(w);
    assign sum   = sub ? (w_ext - inc) : (w_ext + inc);

    always_comb begin
        if (sum > W_MAX) begin
            w_next = W_MAX[WW-1:0];
        end else if (sum < W_MIN) begin
            w_next = W_MIN[WW-1:0];
        end else begin
            w_next = sum[WW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w <= '0;
        end else if (en) begin
            w <= w_next;
        end
    end

endmodule

// File: rtl/lms_sign_updater.sv
// Four-tap sign-error LMS weight updater built from shifts and adders.
module lms_sign_updater
    import lms_upd_pkg::*;
#(
    parameter int DW       = 16,
    parameter int WW       = 16,
    parameter int MU_EXTRA = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [DW-1:0] d_i,
    input  logic signed [DW-1:0] x0_i,
    input  logic signed [DW-1:0] x1_i,
    input  logic signed [DW-1:0] x2_i,
    input  logic signed [DW-1:0] x3_i,
    output logic signed [WW-1:0] w0_o,
    output logic signed [WW-1:0] w1_o,
    output logic signed [WW-1:0] w2_o,
    output logic signed [WW-1:0] w3_o
);

    localparam int NTAP    = 4;
    localparam int STEP_SH = $clog2(NTAP) + MU_EXTRA;
    localparam int EW      = DW + 1;
    localparam int PW      = $clog2(EW);
    localparam int SHW     = $clog2(DW + STEP_SH);

    upd_state_e state_q, state_d;

    logic signed [EW-1:0] err_q;
    logic signed [DW-1:0] x_q [NTAP];
    logic signed [WW-1:0] w_arr [NTAP];
    logic                 sgn_q;
    logic                 skip_q;
    logic [SHW-1:0]       sh_q;

    logic [EW-1:0]        mag;
    logic [PW-1:0]        lead_pos;
    logic                 lead_none;
    logic                 commit_en;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:   state_d = upd_i ? ST_GRADE : ST_WAIT;
            ST_GRADE:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_WAIT;
            default:   state_d = ST_WAIT;
        endcase
    end

    // capture of error and samples on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            for (int k = 0; k < NTAP; k++) x_q[k] <= '0;
        end else if (state_q == ST_WAIT && upd_i) begin
            err_q  <= EW'(d_i) - EW'(y_i);
            x_q[0] <= x0_i;
            x_q[1] <= x1_i;
            x_q[2] <= x2_i;
            x_q[3] <= x3_i;
        end
    end

    // sign-magnitude split and shift control word
    assign mag = err_q[EW-1] ? EW'(-err_q) : EW'(err_q);

    lms_lead_one #(.MW(EW)) u_lead (
        .mag  (mag),
        .pos  (lead_pos),
        .none (lead_none)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sgn_q  <= 1'b0;
            skip_q <= 1'b1;
            sh_q   <= '0;
        end else if (state_q == ST_GRADE) begin
            sgn_q  <= err_q[EW-1];
            skip_q <= lead_none;
            sh_q   <= SHW'(DW - 1 + STEP_SH - int'(lead_pos));
        end
    end

    // output process: weight write enable
    always_comb begin
        commit_en = 1'b0;
        unique case (state_q)
            ST_WAIT:   commit_en = 1'b0;
            ST_GRADE:  commit_en = 1'b0;
            ST_COMMIT: commit_en = ~skip_q;
            default:   commit_en = 1'b0;
        endcase
    end

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        lms_tap_cell #(.DW(DW), .WW(WW), .SHW(SHW)) u_cell (
            .clk (clk),
            .rst (rst),
            .en  (commit_en),
            .sub (sgn_q),
            .sh  (sh_q),
            .x   (x_q[k]),
            .w   (w_arr[k])
        );
    end

    assign w0_o = w_arr[0];
    assign w1_o = w_arr[1];
    assign w2_o = w_arr[2];
    assign w3_o = w_arr[3];

endmodule

// File: rtl/lms_upd_chk.sv
// Property checker for the weight updater, attached by bind.
module lms_upd_chk
    import lms_upd_pkg::*;
#(
    parameter int DW = 16,
    parameter int WW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 upd_i,
    input logic signed [DW-1:0] y_i,
    input logic signed [DW-1:0] d_i,
    input logic signed [DW-1:0] x0_i,
    input logic signed [WW-1:0] w0_o,
    input logic signed [WW-1:0] w1_o,
    input logic signed [WW-1:0] w2_o,
    input logic signed [WW-1:0] w3_o,
    input upd_state_e           state
);

    logic rst_q = 1'b0;
    logic pend_zero;
    logic pend_up0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            pend_zero <= 1'b1;
            pend_up0  <= 1'b0;
        end else if (state == ST_WAIT && upd_i) begin
            pend_zero <= (d_i == y_i);
            pend_up0  <= (d_i < y_i) == (x0_i < 0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_clear_R1: assert (w0_o == 0 && w1_o == 0 && w2_o == 0 && w3_o == 0)
                else $error("weights not cleared after reset");
        end
    end

    assert_zero_err_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT && pend_zero) |=>
            ($stable(w0_o) && $stable(w1_o) && $stable(w2_o) && $stable(w3_o)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_COMMIT) |=>
            ($stable(w0_o) && $stable(w1_o) && $stable(w2_o) && $stable(w3_o)));

    assert_dir_up_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT && !pend_zero && pend_up0) |=> (w0_o >= $past(w0_o)));

    assert_dir_down_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT && !pend_zero && !pend_up0) |=> (w0_o <= $past(w0_o)));

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && upd_i) |=> (state == ST_GRADE));

    assert_wait_stay_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !upd_i) |=> (state == ST_WAIT));

    assert_grade_next_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GRADE) |=> (state == ST_COMMIT));

    assert_commit_next_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT) |=> (state == ST_WAIT));

endmodule

bind lms_sign_updater lms_upd_chk #(.DW(DW), .WW(WW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .upd_i (upd_i),
    .y_i   (y_i),
    .d_i   (d_i),
    .x0_i  (x0_i),
    .w0_o  (w0_o),
    .w1_o  (w1_o),
    .w2_o  (w2_o),
    .w3_o  (w3_o),
    .state (state_q)
);

// File: tb/sim_lms_sign_updater.sv
`timescale 1ns/1ps
module sim_lms_sign_updater;

    localparam int DW = 16;
    localparam int WW = 16;
    localparam int MU_EXTRA = 0;
    localparam int STEP = 2 + MU_EXTRA;
    localparam int WMAX = (1 <<< (WW-1)) - 1;
    localparam int WMIN = -(1 <<< (WW-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd = 1'b0;
    logic signed [DW-1:0] y = '0, d = '0;
    logic signed [DW-1:0] x [4];
    logic signed [WW-1:0] w [4];

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 1'b0;

    // reference model state
    int w_m [4];
    int w_pend [4];
    int busy = 0;

    always #2.5 clk = ~clk;

    lms_sign_updater #(.DW(DW), .WW(WW), .MU_EXTRA(MU_EXTRA)) u0 (
        .clk(clk), .rst(rst), .upd_i(upd), .y_i(y), .d_i(d),
        .x0_i(x[0]), .x1_i(x[1]), .x2_i(x[2]), .x3_i(x[3]),
        .w0_o(w[0]), .w1_o(w[1]), .w2_o(w[2]), .w3_o(w[3])
    );

    function automatic int clamp(int v);
        if (v > WMAX) return WMAX;
        if (v < WMIN) return WMIN;
        return v;
    endfunction

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) w_m[k] = 0;
            busy = 0;
        end else if (busy > 0) begin
            busy = busy - 1;
            if (busy == 0)
                for (int k = 0; k < 4; k++) w_m[k] = w_pend[k];
        end else if (upd) begin
            int e, mag, p, sh;
            e = int'(d) - int'(y);
            mag = (e < 0) ? -e : e;
            for (int k = 0; k < 4; k++) w_pend[k] = w_m[k];
            if (mag != 0) begin
                p = 0;
                for (int i = 0; i < 32; i++) if ((mag >> i) & 1) p = i;
                sh = DW - 1 - p + STEP;
                for (int k = 0; k < 4; k++) begin
                    int inc;
                    inc = int'(x[k]) >>> sh;
                    w_pend[k] = clamp((e > 0) ? w_m[k] + inc : w_m[k] - inc);
                end
            end
            busy = 2;
        end
    end

    // compare every clock, half a period after the update edge
    always @(negedge clk) begin
        if (!done) begin
            for (int k = 0; k < 4; k++) begin
                n_cmp++;
                if (int'(w[k]) != w_m[k]) begin
                    n_bad++;
                    $display("FAIL %s tap%0d: got %0d expected %0d", tag, k, w[k], w_m[k]);
                end
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(int dv, int yv, int x0, int x1, int x2, int x3);
        d = DW'(dv); y = DW'(yv);
        x[0] = DW'(x0); x[1] = DW'(x1); x[2] = DW'(x2); x[3] = DW'(x3);
        upd = 1'b1;
        step(1);
        upd = 1'b0;
        step(3);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) x[k] = '0;
        step(3);
        // R1: reset state
        tag = "R1";
        rst = 1'b0;
        step(2);

        // R2 / R3: signs and magnitudes of the error
        tag = "R2";
        pulse(1000, 200, 4000, -4000, 1234, -77);
        pulse(-500, 300, 4000, -4000, 1234, -77);
        tag = "R3";
        for (int p = 0; p < 16; p++) pulse(1 <<< p, 0, 30000, -30000, 1023, -1);
        pulse(32767, -32768, 16384, 1, -1, -16384);
        for (int i = 0; i < 20; i++)
            pulse($urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
                  $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
                  $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768);

        // R4: zero error
        tag = "R4";
        pulse(1234, 1234, 30000, -30000, 5000, -5000);

        // R5: strobe low, inputs moving
        tag = "R5";
        for (int i = 0; i < 10; i++) begin
            d = DW'(i * 3000); y = DW'(-i * 1000); x[0] = DW'(i * 100);
            step(1);
        end

        // R6 / R9: strobe held high, only every third cycle accepted
        tag = "R6";
        d = 20000; y = -1000; x[0] = 3000; x[1] = -3000; x[2] = 7; x[3] = -9;
        upd = 1'b1;
        step(12);
        tag = "R9";
        d = -20000; y = 1000;
        step(9);
        upd = 1'b0;
        step(3);

        // R10: samples change after acceptance
        tag = "R10";
        d = 9000; y = 0; x[0] = 100; x[1] = 2000; x[2] = -3000; x[3] = 32767;
        upd = 1'b1;
        step(1);
        upd = 1'b0;
        x[0] = -32768; x[1] = -32768; x[2] = -32768; x[3] = -32768;
        step(3);

        // R7: drive to positive limit
        tag = "R7";
        rst = 1'b1; step(1); rst = 1'b0; step(1);
        for (int i = 0; i < 7; i++) pulse(32767, -32768, 32767, 32767, -32768, 20000);

        // R8: drive to negative limit
        tag = "R8";
        rst = 1'b1; step(1); rst = 1'b0; step(1);
        for (int i = 0; i < 7; i++) pulse(-32768, 32767, 32767, -32768, 32767, -20000);

        // R1: reset in the middle of an update
        tag = "R1";
        d = 30000; y = 0; x[0] = 9999; upd = 1'b1;
        step(1);
        upd = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(4);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule